// File: doc/BRIEF.md
# Oscillator Sub-Band Lock Search Controller

This controller finds an oscillator and oscillator sub-band at which a frequency synthesizer loop can lock. The oscillator bank is seen as a single ordered line of 24 positions: three oscillators, each with eight sub-bands. A search starts from a given oscillator and sub-band. The controller writes the 8-bit oscillator control register, waits a programmable settling time, and then reads a 3-bit tuning-voltage indicator. The indicator says one of three things: the loop is locked, the tuning voltage is pinned at the bottom (step one position down), or it is pinned at the top (step one position up).

The walk crosses oscillator boundaries. Sub-band 0 of one oscillator sits next to sub-band 7 of the oscillator below it. The walk ends at the first position that locks. It ends with a failure flag when any of these happens:
- a step would leave the bank;
- the direction would reverse a second time;
- a 25th step would be needed.

The divider select is copied into the register unchanged. The loop, the charge pump and the choice of channel are handled elsewhere.

Top module: `vco_band_search`

## Requirements
- R1: After reset, `vco_reg_o` is 0x6D (oscillator 1, sub-band 5, lock detect on, divider select 01), and `vco_wr_o`, `done_o`, `locked_o` and `fail_o` are all 0.
- R2: The controller accepts a start pulse only while no search is running. On the cycle after the start edge it asserts `vco_wr_o` for one cycle with `vco_reg_o` = {select[7:6], sub-band[5:3], 1[2], divider[1:0]}. The select value 01/10/11 means oscillator 1/2/3. An initial select of 00 is treated as oscillator 1.
- R3: The indicator is sampled `settle_i`+1 clock edges after the edge that produced a write strobe. The value of `settle_i` is captured at start. The next strobe, or the result flags, appear on the cycle after that sampling edge.
- R4: Indicator 000 moves the search one position down. Sub-band 0 of oscillator k moves to sub-band 7 of oscillator k-1.
- R5: Indicator 111 moves the search one position up. Sub-band 7 of oscillator k moves to sub-band 0 of oscillator k+1.
- R6: Any indicator from 001 to 110 ends the search with `done_o`=1, `locked_o`=1 and `fail_o`=0. No further write occurs, and `vco_reg_o` keeps the locked setting.
- R7: A step requested below oscillator 1 sub-band 0, or above oscillator 3 sub-band 7, ends the search with `done_o`=1, `fail_o`=1 and `locked_o`=0, without a write.
- R8: A step whose direction differs from the previous step counts as a reversal. A step that would make the second reversal ends the search as a failure, without a write.
- R9: At most 24 steps are taken. A search that would need a 25th step ends as a failure, without a write.
- R10: Every register value written has a nonzero select field and the lock-detect bit set.
- R11: A start pulse during a running search is ignored. The sequence of writes is unchanged.
- R12: The result flags hold until the next accepted start, which clears them on the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| init_vsel_i | input | 2 | Initial oscillator select |
| init_sub_i | input | 3 | Initial sub-band |
| div_sel_i | input | 2 | Divider select, copied into bits 1:0 |
| settle_i | input | SETTLE_W | Settling wait in cycles, captured at start |
| lock_ind_i | input | 3 | Tuning-voltage indicator |
| vco_reg_o | output | 8 | Oscillator control register value |
| vco_wr_o | output | 1 | One-cycle write strobe for `vco_reg_o` |
| done_o | output | 1 | Search finished |
| locked_o | output | 1 | Search finished with lock |
| fail_o | output | 1 | Search finished without lock |

## Verification
The first write strobe is due one cycle after the start edge. Every later strobe, and the final flags, are due exactly `settle_i`+1 edges after the edge that raised the previous strobe. The bench holds the indicator steady from the strobe onward and counts exactly that many rising edges. It then samples at the following falling edge, so it catches any premature or late strobe. After each result it waits a few more cycles to confirm that no write follows and that the flags hold.

// File: rtl/vsrch_pkg.sv
package vsrch_pkg;
  localparam int VSEL_W        = 2;
  localparam int SUB_W         = 3;
  localparam int DIV_W         = 2;
  localparam int REG_W         = 8;
  localparam int POS_W         = VSEL_W + SUB_W;
  localparam int BANDS_PER_VCO = 1 << SUB_W;

  typedef enum logic {ST_IDLE, ST_SETTLE} state_t;
  typedef enum logic [1:0] {IND_LOCK, IND_DOWN, IND_UP} ind_t;

  // 000: pinned low -> go down, 111: pinned high -> go up, else locked
  function automatic ind_t classify(input logic [2:0] ind);
    if (ind == 3'b000)      return IND_DOWN;
    else if (ind == 3'b111) return IND_UP;
    else                    return IND_LOCK;
  endfunction

  // linear position: (oscillator index) * 8 + sub-band; select 00 taken as oscillator 1
  function automatic logic [POS_W-1:0] pos_of(input logic [VSEL_W-1:0] vsel,
                                              input logic [SUB_W-1:0]  sub);
    logic [VSEL_W-1:0] idx;
    idx = (vsel == '0) ? '0 : vsel - 1'b1;
    return {idx, sub};
  endfunction

  function automatic logic [REG_W-1:0] reg_of(input logic [POS_W-1:0] pos,
                                              input logic [DIV_W-1:0] div);
    logic [VSEL_W-1:0] vsel;
    vsel = pos[POS_W-1:SUB_W] + 1'b1;
    return {vsel, pos[SUB_W-1:0], 1'b1, div};
  endfunction

  function automatic logic [POS_W-1:0] reg_pos(input logic [REG_W-1:0] r);
    logic [VSEL_W-1:0] idx;
    idx = r[REG_W-1 -: VSEL_W] - 1'b1;
    return {idx, r[REG_W-VSEL_W-1 -: SUB_W]};
  endfunction
endpackage

// File: rtl/vsrch_step.sv
module vsrch_step
  import vsrch_pkg::*;
#(
  parameter int POS_N = 24
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             up_i,
  output logic [POS_W-1:0] nxt_o,
  output logic             edge_o
);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(POS_N - 1);

  always_comb begin
    edge_o = up_i ? (pos_i == TOP_POS) : (pos_i == '0);
    nxt_o  = up_i ? pos_i + 1'b1 : pos_i - 1'b1;
  end
endmodule

// File: rtl/vsrch_guard.sv
module vsrch_guard #(
  parameter int MAX_STEPS = 24,
  parameter int MAX_REV   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic take_i,
  input  logic up_i,
  output logic over_o
);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam int REV_W  = $clog2(MAX_REV + 2);

  logic [STEP_W-1:0] steps_q;
  logic [REV_W-1:0]  revs_q;
  logic              have_dir_q;
  logic              last_up_q;
  logic              turn;

  always_comb begin
    turn   = have_dir_q && (up_i != last_up_q);
    over_o = (steps_q >= STEP_W'(MAX_STEPS)) ||
             (turn && (revs_q >= REV_W'(MAX_REV)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q    <= '0;
      revs_q     <= '0;
      have_dir_q <= 1'b0;
      last_up_q  <= 1'b0;
    end else if (clear_i) begin
      steps_q    <= '0;
      revs_q     <= '0;
      have_dir_q <= 1'b0;
      last_up_q  <= 1'b0;
    end else if (take_i) begin
      steps_q    <= steps_q + 1'b1;
      revs_q     <= revs_q + REV_W'(turn);
      have_dir_q <= 1'b1;
      last_up_q  <= up_i;
    end
  end

  a_r9_steps_capped: assert property (@(posedge clk) disable iff (!rst_n)
    steps_q <= STEP_W'(MAX_STEPS));
  a_r8_rev_capped: assert property (@(posedge clk) disable iff (!rst_n)
    revs_q <= REV_W'(MAX_REV));
  a_r9_no_take_when_over: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !over_o);
endmodule

// File: rtl/vsrch_settle.sv
module vsrch_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r3_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) && !load_i |=> cnt_q == '0);
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
  import vsrch_pkg::*;
#(
  parameter int NUM_VCO   = 3,
  parameter int SETTLE_W  = 8,
  parameter int MAX_STEPS = 24,
  parameter int MAX_REV   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          init_vsel_i,
  input  logic [2:0]          init_sub_i,
  input  logic [1:0]          div_sel_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [2:0]          lock_ind_i,
  output logic [7:0]          vco_reg_o,
  output logic                vco_wr_o,
  output logic                done_o,
  output logic                locked_o,
  output logic                fail_o
);
  localparam int POS_N = NUM_VCO * BANDS_PER_VCO;
  localparam logic [REG_W-1:0] RESET_REG = 8'h6D;

  state_t               state_q;
  logic [POS_W-1:0]     pos_q;
  logic [DIV_W-1:0]     div_q;
  logic [SETTLE_W-1:0]  settle_q;

  // named internal events
  logic                 start_evt;
  logic                 sample_evt;
  logic                 lock_evt;
  logic                 step_req;
  logic                 step_ok;
  logic                 fail_evt;
  logic                 dir_up;
  ind_t                 cls;
  logic                 expired;
  logic                 edge_hit;
  logic                 limit_hit;
  logic [POS_W-1:0]     nxt_pos;
  logic [POS_W-1:0]     init_pos;
  logic [SETTLE_W-1:0]  load_val;

  always_comb begin
    cls        = classify(lock_ind_i);
    dir_up     = (cls == IND_UP);
    start_evt  = start_i && (state_q == ST_IDLE);
    sample_evt = (state_q == ST_SETTLE) && expired;
    lock_evt   = sample_evt && (cls == IND_LOCK);
    step_req   = sample_evt && (cls != IND_LOCK);
    fail_evt   = step_req && (edge_hit || limit_hit);
    step_ok    = step_req && !(edge_hit || limit_hit);
    init_pos   = pos_of(init_vsel_i, init_sub_i);
    if (init_pos >= POS_W'(POS_N)) init_pos = POS_W'(POS_N - 1);
    load_val   = start_evt ? settle_i : settle_q;
  end

  vsrch_step #(.POS_N(POS_N)) step_i (
    .pos_i  (pos_q),
    .up_i   (dir_up),
    .nxt_o  (nxt_pos),
    .edge_o (edge_hit)
  );

  vsrch_guard #(.MAX_STEPS(MAX_STEPS), .MAX_REV(MAX_REV)) guard_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_evt),
    .take_i  (step_ok),
    .up_i    (dir_up),
    .over_o  (limit_hit)
  );

  vsrch_settle #(.CNT_W(SETTLE_W)) settle_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_evt || step_ok),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pos_q     <= '0;
      div_q     <= '0;
      settle_q  <= '0;
      vco_reg_o <= RESET_REG;
      vco_wr_o  <= 1'b0;
      done_o    <= 1'b0;
      locked_o  <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      vco_wr_o <= 1'b0;
      if (start_evt) begin
        state_q   <= ST_SETTLE;
        pos_q     <= init_pos;
        div_q     <= div_sel_i;
        settle_q  <= settle_i;
        vco_reg_o <= reg_of(init_pos, div_sel_i);
        vco_wr_o  <= 1'b1;
        done_o    <= 1'b0;
        locked_o  <= 1'b0;
        fail_o    <= 1'b0;
      end else if (lock_evt) begin
        state_q  <= ST_IDLE;
        done_o   <= 1'b1;
        locked_o <= 1'b1;
      end else if (fail_evt) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
        fail_o  <= 1'b1;
      end else if (step_ok) begin
        pos_q     <= nxt_pos;
        vco_reg_o <= reg_of(nxt_pos, div_q);
        vco_wr_o  <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [SETTLE_W:0] gap_q;  // cycles since the last write edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (start_evt || step_ok)  gap_q <= '0;
    else if (gap_q != '1)           gap_q <= gap_q + 1'b1;
  end

  a_r3_sample_timing: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> gap_q == {1'b0, settle_q});
  a_r10_fields: assert property (@(posedge clk) disable iff (!rst_n)
    vco_wr_o |-> (vco_reg_o[7:6] != 2'b00) && vco_reg_o[2]);
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    vco_wr_o && $past(sample_evt) && ($past(lock_ind_i) == 3'b000) |->
      reg_pos(vco_reg_o) == reg_pos($past(vco_reg_o)) - 1'b1);
  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    vco_wr_o && $past(sample_evt) && ($past(lock_ind_i) == 3'b111) |->
      reg_pos(vco_reg_o) == reg_pos($past(vco_reg_o)) + 1'b1);
  a_r6_lock_ends: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> done_o && locked_o && !fail_o && !vco_wr_o);
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_o && fail_o));
  a_r12_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(locked_o) && $stable(fail_o));
  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) && !sample_evt |=> !vco_wr_o);
endmodule

// File: tb/vco_band_search_tb_top.sv
module vco_band_search_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] init_vsel_i = 2'b01;
  logic [2:0] init_sub_i = 3'd0;
  logic [1:0] div_sel_i = 2'b00;
  logic [7:0] settle_i = 8'd0;
  logic [2:0] lock_ind_i = 3'b001;
  logic [7:0] vco_reg_o;
  logic       vco_wr_o, done_o, locked_o, fail_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  vco_band_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .init_vsel_i(init_vsel_i), .init_sub_i(init_sub_i), .div_sel_i(div_sel_i),
    .settle_i(settle_i), .lock_ind_i(lock_ind_i),
    .vco_reg_o(vco_reg_o), .vco_wr_o(vco_wr_o),
    .done_o(done_o), .locked_o(locked_o), .fail_o(fail_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bench view of the register: oscillator number (1..3) and sub-band from a linear index
  function automatic logic [7:0] exp_reg(input int p, input logic [1:0] dv);
    int osc;
    int sb;
    osc = p / 8 + 1;
    sb  = p % 8;
    return 8'((osc << 6) | (sb << 3) | 4 | dv);
  endfunction

  // mode 0: target position t; mode 1: up until a, then down until b, then up
  function automatic logic [2:0] pick_ind(input int mode, input int p, input int t,
                                          input int a, input int b, inout int phase,
                                          input logic [2:0] lockv);
    if (mode == 0) begin
      if (p < t) return 3'b111;
      if (p > t) return 3'b000;
      return lockv;
    end
    if (phase == 0 && p >= a) phase = 1;
    if (phase == 1 && p <= b) phase = 2;
    return (phase == 1) ? 3'b000 : 3'b111;
  endfunction

  task automatic run_search(input logic [1:0] vs, input logic [2:0] sb, input logic [1:0] dv,
                            input int st, input int mode, input int t, input int a,
                            input int b, input logic [2:0] lockv, input bit poke_busy);
    int p, last_dir, revs, steps, phase, dir, np;
    logic [2:0] ind;
    logic [7:0] held;
    bit fin, lk;
    p = ((vs == 2'b00) ? 0 : int'(vs) - 1) * 8 + int'(sb);
    last_dir = 0; revs = 0; steps = 0; phase = 0; fin = 0; lk = 0;
    @(negedge clk);
    init_vsel_i = vs; init_sub_i = sb; div_sel_i = dv; settle_i = 8'(st);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(vco_wr_o == 1'b1, "R2 first strobe", vco_wr_o, 1);
    check(vco_reg_o == exp_reg(p, dv), "R2 first value", vco_reg_o, exp_reg(p, dv));
    check(!done_o && !locked_o && !fail_o, "R12 flags cleared at start",
          {done_o, locked_o, fail_o}, 0);
    while (!fin) begin
      ind = pick_ind(mode, p, t, a, b, phase, lockv);
      lock_ind_i = ind;
      if (poke_busy && steps == 1) start_i = 1'b1;
      for (int k = 0; k <= st; k++) begin
        @(posedge clk);
        start_i <= 1'b0;
      end
      @(negedge clk);
      if (ind != 3'b000 && ind != 3'b111) begin
        fin = 1; lk = 1;
        check(done_o && locked_o && !fail_o && !vco_wr_o, "R6 lock result",
              {done_o, locked_o, fail_o, vco_wr_o}, 4'b1100);
        check(vco_reg_o == exp_reg(p, dv), "R6 locked value kept", vco_reg_o, exp_reg(p, dv));
      end else begin
        dir = (ind == 3'b111) ? 1 : 2;
        np = (dir == 1) ? p + 1 : p - 1;
        if (np < 0 || np > 23 || steps == 24 ||
            (last_dir != 0 && dir != last_dir && revs == 1)) begin
          fin = 1;
          check(done_o && fail_o && !locked_o && !vco_wr_o,
                (np < 0 || np > 23) ? "R7 edge fail" :
                (steps == 24) ? "R9 step limit fail" : "R8 reversal fail",
                {done_o, locked_o, fail_o, vco_wr_o}, 4'b1010);
        end else begin
          if (last_dir != 0 && dir != last_dir) revs++;
          last_dir = dir; steps++; p = np;
          check(vco_wr_o == 1'b1, "R3 strobe timing", vco_wr_o, 1);
          check(vco_reg_o == exp_reg(p, dv), (dir == 1) ? "R5 step up value" : "R4 step down value",
                vco_reg_o, exp_reg(p, dv));
          check(vco_reg_o[7:6] != 2'b00 && vco_reg_o[2], "R10 fields", vco_reg_o, 0);
        end
      end
    end
    held = vco_reg_o;
    repeat (3) @(negedge clk);
    check(!vco_wr_o && vco_reg_o == held, "R12 no write after result", vco_reg_o, held);
    check(done_o && locked_o == lk && fail_o == !lk, "R12 flags hold",
          {done_o, locked_o, fail_o}, {1'b1, lk, !lk});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(vco_reg_o == 8'h6D, "R1 reset register", vco_reg_o, 8'h6D);
    check(!vco_wr_o && !done_o && !locked_o && !fail_o, "R1 reset flags",
          {vco_wr_o, done_o, locked_o, fail_o}, 0);
    rst_n = 1'b1;
    // directed corner cases
    run_search(2'b01, 3'd5, 2'b01, 2, 0, 5, 0, 0, 3'b011, 0);   // R2 R6 immediate lock, 0x6D
    run_search(2'b00, 3'd2, 2'b10, 0, 0, 2, 0, 0, 3'b110, 0);   // R2 select 00 as osc 1
    run_search(2'b10, 3'd1, 2'b00, 1, 0, 5, 0, 0, 3'b001, 0);   // R4 cross down
    run_search(2'b01, 3'd6, 2'b11, 3, 0, 10, 0, 0, 3'b100, 0);  // R5 cross up
    run_search(2'b01, 3'd2, 2'b01, 0, 0, -1, 0, 0, 3'b001, 0);  // R7 bottom
    run_search(2'b11, 3'd5, 2'b01, 1, 0, 24, 0, 0, 3'b001, 0);  // R7 top
    run_search(2'b01, 3'd5, 2'b00, 0, 1, 0, 8, 3, 3'b001, 0);   // R8 second reversal
    run_search(2'b10, 3'd4, 2'b10, 0, 1, 0, 23, 0, 3'b001, 0);  // R9 25th step
    run_search(2'b01, 3'd3, 2'b01, 2, 0, 9, 0, 0, 3'b010, 1);   // R11 start while busy
    // constrained random
    void'($urandom(32'h5eed_0042));
    for (int n = 0; n < 30; n++) begin
      logic [1:0] vs;
      logic [2:0] lv;
      vs = 2'($urandom_range(1, 3));
      lv = 3'($urandom_range(1, 6));
      run_search(vs, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                 int'($urandom_range(0, 6)), 0, int'($urandom_range(0, 25)) - 1,
                 0, 0, lv, n % 7 == 3);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule